// File: doc/BRIEF.md
# Serial-Grant Interrupt Priority Controller

This block gathers interrupt requests from a row of device cells, presents them to the processor on one shared request line, and resolves which device is served when the processor acknowledges. Each cell latches its own request into a pending flag and owns a fixed vector address. The acknowledge enters the first cell and travels cell by cell: a cell with nothing pending forwards it, while the first cell that holds a pending flag keeps it, so no cell further along sees it. That cell alone places its vector on the vector bus, and its pending flag is cleared when the acknowledge is withdrawn.

A small processor-side generator produces the acknowledge. While interrupts are enabled and the shared line is high, it raises acknowledge for a fixed number of cycles, drops it for at least one cycle, and then may answer the next request. Cell count, vector width, vector base and spacing, and acknowledge length are parameters.

Top module: `prio_chain_top`

## Requirements
- R1: A high `devReq[i]` at a rising clock edge sets pending flag i at that edge; the flag then stays set until that cell is served, and `pendingOut` shows all flags.
- R2: `intReq` is high in exactly the cycles in which at least one pending flag is set.
- R3: When `intEnable` and `intReq` are both high at an edge while the generator is idle, `intAck` goes high after that edge, stays high for ACK_LEN cycles (default 2) whatever `intEnable` does, and then stays low for at least one cycle.
- R4: Cell 0 has the highest priority and priority falls with index; during an acknowledge the served cell is the lowest-index cell with its flag set.
- R5: During an acknowledge with at least one flag set, `vecValid` is high and `vecBus` equals VEC_BASE + VEC_STEP × (index of the served cell), default 0x40 + 4 × index; exactly one cell drives it.
- R6: Whenever `intAck` is low, `vecValid` is low and `vecBus` is zero.
- R7: At the edge where `intAck` falls, the served cell's flag clears and every other flag is unchanged.
- R8: If the served cell's `devReq` is high at the edge where its flag would clear, the flag stays set.
- R9: While `intEnable` is low no acknowledge starts and pending flags are held.
- R10: After reset all flags, `intReq`, `intAck`, `vecValid` and `vecBus` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| devReq | input | N | Per-cell request sources, sampled each edge |
| intEnable | input | 1 | Processor accepts interrupts when high |
| intReq | output | 1 | Shared request line, OR of pending flags |
| intAck | output | 1 | Acknowledge from the processor side, enters cell 0 |
| vecValid | output | 1 | A cell is driving the vector bus |
| vecBus | output | VEC_W | Vector of the served cell, zero otherwise |
| pendingOut | output | N | Current pending flags |

## Verification
A request driven before an edge appears on `pendingOut` and `intReq` one cycle later; raising `intEnable` with a request pending makes `intAck` high one cycle later, and the vector is valid in that same cycle because the grant path is combinational. The flag clears and `intAck` falls ACK_LEN cycles after acknowledge rose, with one further quiet cycle before another acknowledge can start. The bench drives inputs and samples outputs on falling edges, counting each of these cycles explicitly from its own model of the flags, so every check lands in the cycle in which the result is due.

// File: rtl/prio_chain_pkg.sv
package prio_chain_pkg;

  typedef enum logic [1:0] {
    GEN_IDLE = 2'd0,
    GEN_ACK  = 2'd1,
    GEN_REST = 2'd2
  } genState_t;

  typedef struct packed {
    logic ackOn;     // acknowledge entering the first cell
    logic clrGrant;  // last acknowledge cycle: retire the served flag
  } chainStrobe_t;

endpackage

// File: rtl/prio_chain_ctrl.sv
module prio_chain_ctrl
  import prio_chain_pkg::*;
#(
  parameter int ACK_LEN = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         intReq,
  input  logic         intEnable,
  output chainStrobe_t strobe
);

  localparam int CW = (ACK_LEN > 1) ? $clog2(ACK_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(ACK_LEN - 1);

  genState_t state;
  logic [CW-1:0] ackCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= GEN_IDLE;
      ackCnt <= '0;
    end else begin
      case (state)
        GEN_IDLE: begin
          if (intEnable && intReq) begin
            state  <= GEN_ACK;
            ackCnt <= '0;
          end
        end
        GEN_ACK: begin
          if (ackCnt == LAST) state <= GEN_REST;
          else                ackCnt <= ackCnt + 1'b1;
        end
        default: state <= GEN_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.ackOn    = (state == GEN_ACK);
    strobe.clrGrant = (state == GEN_ACK) && (ackCnt == LAST);
  end

  // R3: acknowledge only starts from an enabled, pending request
  a_r3_ack_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.ackOn) |-> $past(intReq && intEnable));

  // R3: a quiet cycle follows every acknowledge
  a_r3_rest_gap: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strobe.ackOn) |=> !strobe.ackOn);

  // R9: disabled while idle means no acknowledge next cycle
  a_r9_no_ack_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (state == GEN_IDLE && !intEnable) |=> !strobe.ackOn);

endmodule

// File: rtl/prio_chain_path.sv
module prio_chain_path
  import prio_chain_pkg::*;
#(
  parameter int N        = 8,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64,
  parameter int VEC_STEP = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [N-1:0]     devReq,
  input  chainStrobe_t     strobe,
  output logic [N-1:0]     pending,
  output logic             intReq,
  output logic             vecValid,
  output logic [VEC_W-1:0] vecBus
);

  logic [N-1:0] chainIn;   // acknowledge arriving at each cell
  logic [N-1:0] grant;     // cell holds the acknowledge
  logic [VEC_W-1:0] cellVec [N];

  assign chainIn[0] = strobe.ackOn;

  for (genvar i = 0; i < N; i++) begin : g_cell
    localparam logic [VEC_W-1:0] MY_VEC = VEC_W'(VEC_BASE + VEC_STEP * i);

    assign grant[i]   = chainIn[i] & pending[i];
    assign cellVec[i] = grant[i] ? MY_VEC : '0;

    if (i < N - 1) begin : g_pass
      assign chainIn[i+1] = chainIn[i] & ~pending[i];
    end

    // R1: a sampled request always lands in the flag
    a_r1_capture: assert property (@(posedge clk) disable iff (!rstN)
      devReq[i] |=> pending[i]);

    // R7: the served flag retires when acknowledge ends
    a_r7_retire: assert property (@(posedge clk) disable iff (!rstN)
      (grant[i] && strobe.clrGrant && !devReq[i]) |=> !pending[i]);

    if (i > 0) begin : g_prio
      // R4: a granted cell has no higher-priority neighbour pending
      a_r4_lowest_wins: assert property (@(posedge clk) disable iff (!rstN)
        grant[i] |-> (pending[i-1:0] == '0));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) pending <= '0;
    else       pending <= (pending & ~(grant & {N{strobe.clrGrant}})) | devReq;
  end

  always_comb begin
    vecBus = '0;
    for (int k = 0; k < N; k++) vecBus = vecBus | cellVec[k];
  end

  assign vecValid = |grant;
  assign intReq   = |pending;

  // R5: never more than one cell on the vector bus
  a_r5_single_grant: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));

  // R6: bus quiet outside acknowledge
  a_r6_quiet_bus: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.ackOn |-> (!vecValid && vecBus == '0));

endmodule

// File: rtl/prio_chain_top.sv
module prio_chain_top
  import prio_chain_pkg::*;
#(
  parameter int N        = 8,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64,
  parameter int VEC_STEP = 4,
  parameter int ACK_LEN  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [N-1:0]     devReq,
  input  logic             intEnable,
  output logic             intReq,
  output logic             intAck,
  output logic             vecValid,
  output logic [VEC_W-1:0] vecBus,
  output logic [N-1:0]     pendingOut
);

  chainStrobe_t strobe;

  prio_chain_ctrl #(.ACK_LEN(ACK_LEN)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .intReq    (intReq),
    .intEnable (intEnable),
    .strobe    (strobe)
  );

  prio_chain_path #(
    .N(N), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .devReq   (devReq),
    .strobe   (strobe),
    .pending  (pendingOut),
    .intReq   (intReq),
    .vecValid (vecValid),
    .vecBus   (vecBus)
  );

  assign intAck = strobe.ackOn;

endmodule

// File: tb/prio_chain_top_bench.sv
`timescale 1ns/1ps
module prio_chain_top_bench;

  localparam int N = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] devReq = '0;
  logic intEnable = 1'b0;
  logic intReq, intAck, vecValid;
  logic [7:0] vecBus;
  logic [N-1:0] pendingOut;

  int checks = 0;
  int failures = 0;
  logic [N-1:0] expPend = '0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prio_chain_top u_prio_chain_top (
    .clk(clk), .rstN(rstN), .devReq(devReq), .intEnable(intEnable),
    .intReq(intReq), .intAck(intAck), .vecValid(vecValid),
    .vecBus(vecBus), .pendingOut(pendingOut)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int lowestIdx(input logic [N-1:0] m);
    for (int k = 0; k < N; k++) if (m[k]) return k;
    return -1;
  endfunction

  // called at a falling edge; returns at a falling edge
  task automatic raise(input logic [N-1:0] mask);
    devReq = mask;
    @(negedge clk);
    devReq = '0;
    expPend = expPend | mask;
    chk("R1", "pending after request", 32'(pendingOut), 32'(expPend));
    chk("R2", "shared request line", 32'(intReq), 32'(expPend != '0));
  endtask

  task automatic serveOne();
    int idx = lowestIdx(expPend);
    intEnable = 1'b1;
    @(negedge clk);
    intEnable = 1'b0;
    chk("R3", "ack rises one cycle after enable", 32'(intAck), 32'd1);
    chk("R4", "served cell index", 32'(vecBus), 32'(8'h40 + 4 * idx));
    chk("R5", "vector valid", 32'(vecValid), 32'd1);
    @(negedge clk);
    chk("R3", "ack held second cycle", 32'(intAck), 32'd1);
    chk("R5", "vector held", 32'(vecBus), 32'(8'h40 + 4 * idx));
    chk("R7", "flag kept during ack", 32'(pendingOut), 32'(expPend));
    @(negedge clk);
    expPend[idx] = 1'b0;
    chk("R3", "ack low after ACK_LEN", 32'(intAck), 32'd0);
    chk("R7", "served flag cleared", 32'(pendingOut), 32'(expPend));
    chk("R6", "bus quiet", 32'({vecValid, vecBus}), 32'd0);
    @(negedge clk);
    chk("R3", "rest cycle", 32'(intAck), 32'd0);
  endtask

  task automatic testReset();
    chk("R10", "flags", 32'(pendingOut), 32'd0);
    chk("R10", "request", 32'(intReq), 32'd0);
    chk("R10", "ack", 32'(intAck), 32'd0);
    chk("R10", "vector", 32'({vecValid, vecBus}), 32'd0);
  endtask

  task automatic testDrain(input logic [N-1:0] mask);
    raise(mask);
    while (expPend != '0) serveOne();
    chk("R2", "line drops when drained", 32'(intReq), 32'd0);
  endtask

  task automatic testDisabled();
    raise(8'b0010_1000);
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      chk("R9", "no ack while disabled", 32'(intAck), 32'd0);
      chk("R9", "flags held", 32'(pendingOut), 32'(expPend));
      chk("R6", "bus quiet while disabled", 32'({vecValid, vecBus}), 32'd0);
    end
    while (expPend != '0) serveOne();
  endtask

  task automatic testSetWins();
    raise(8'b0000_0100);
    intEnable = 1'b1;
    @(negedge clk);
    intEnable = 1'b0;
    chk("R5", "vector of cell 2", 32'(vecBus), 32'h48);
    @(negedge clk);
    devReq = 8'b0000_0100;
    @(negedge clk);
    devReq = '0;
    chk("R3", "ack dropped", 32'(intAck), 32'd0);
    chk("R8", "new request survives clear", 32'(pendingOut), 32'(expPend));
    @(negedge clk);
    serveOne();
  endtask

  task automatic testLateArrival();
    // a higher cell arrives while a lower one waits disabled
    raise(8'b1000_0000);
    raise(8'b0000_0010);
    serveOne();
    chk("R7", "lower cell untouched", 32'(pendingOut), 32'h80);
    serveOne();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDrain(8'b0000_1000);
    testDrain(8'b0101_0010);
    testDrain(8'hFF);
    testDrain(8'b1000_0000);
    testDisabled();
    testSetWins();
    testLateArrival();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule